// File: doc/BRIEF.md
# Voltage-ID Ramp Controller

This block is the digital core on the regulator side of a serial voltage-identification link. A front end (not part of this block) hands it one decoded command per cycle: an opcode, an address and a payload byte. For each of several output rails the block keeps a target code and a present code, and moves the present code toward the target one code at a time. How fast it moves depends on the command that set the target. Fast and slow ramps are paced by programmable step dividers. A decay ramp is not paced by the block at all: it only ever moves down, one code per external discharge strobe.

Every ramp command preempts the ramp in progress. The block also keeps a light-load power state per rail. A request for a higher code forces the rail back to full power. A host-written maximum-code register refuses targets above it. Each command gets exactly one response code on the cycle after it is accepted. While the socket-present input is low, no rail moves.

Top module: `vid_ramp_ctrl`

## Requirements
- R1: Each cycle with `cmd_valid` high produces `rsp_valid` high for exactly the next cycle, carrying a code: 01 = acknowledge, 10 = not supported, 11 = bad address. Without a command, `rsp_valid` stays low.
- R2: Opcode 1 (fast) and opcode 2 (slow) set the target to the payload. The present code then moves one code toward it every F cycles for fast or S cycles for slow. F and S reset to 2 and 8.
- R3: Opcode 5 writes the payload to a register chosen by the address: 30h = maximum code, 31h = fast divider F, 32h = slow divider S. A divider value of 0 acts as 1.
- R4: A ramp command takes effect on the cycle it is accepted. The present code does not jump; it moves from its current value toward the new target at the new command's rate.
- R5: Rail commands address rail 0, 1 and 2 at addresses 00h, 02h and 04h. Any other rail address, and any register write outside 30h..32h, answers 11 and changes nothing.
- R6: Opcode 3 (decay) sets the target. Afterwards the present code moves only down, by one per cycle with `decay_step` high, and never below the target. It never moves up, and it holds without strobes.
- R7: Opcode 4 sets the rail power state from the payload: 0 = full, 1 = light, 2 = very light. An unsupported request is acknowledged and selects the deepest supported state not above it. By default states 0 and 1 are supported.
- R8: A fast or slow command whose target is above the present code puts the rail in power state 0 on the accepting edge. A later downward command does not restore the earlier state.
- R9: The maximum-code register resets to all ones. A ramp command with a payload above it answers 10 and leaves target and present unchanged. A payload equal to it is accepted.
- R10: While `socket_present` is low, no present code changes. When it rises, ramping resumes at the programmed rate.
- R11: Opcodes other than 1 to 5 answer 10 and change nothing.
- R12: `vid_settled[r]` is high exactly when rail r's present code equals its target.
- R13: After reset every rail sits at code 00h, settled, in power state 0, with no response pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| socket_present | input | 1 | High when the socket is occupied; low freezes all rails |
| decay_step | input | 1 | Discharge strobe used by decay ramps |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Opcode |
| cmd_addr | input | ADDR_W | Rail or register address |
| cmd_data | input | DATA_W | Payload byte |
| rsp_valid | output | 1 | Response strobe |
| rsp_code | output | 2 | Response code |
| vid_now | output | NUM_RAILS*DATA_W | Present code per rail, rail 0 in the low byte |
| vid_settled | output | NUM_RAILS | Present equals target per rail |
| pwr_state | output | NUM_RAILS*2 | Power state per rail |

## Verification
The bench measures the exact number of cycles a ramp takes under each divider, including a divider written as zero. A design with an off-by-one pacing counter, or one that steps on the accepting edge, misses those counts. A ramp is interrupted partway in the opposite direction. This catches a design that resets the present code to the old target or finishes the old ramp first. Decay is driven with and without strobes, and with a target above the present code, so any upward or unstrobed movement shows. Other tests probe the maximum-code boundary, bad addresses, unsupported power states, the forced return to full power, and a frozen socket. A design that loads a refused target, answers the wrong code, or ramps while the socket is empty is visible at the ports.

// File: rtl/vidr_pkg.sv
package vidr_pkg;

  localparam int OP_W = 3;

  localparam logic [OP_W-1:0] OP_FAST   = 3'd1;
  localparam logic [OP_W-1:0] OP_SLOW   = 3'd2;
  localparam logic [OP_W-1:0] OP_DECAY  = 3'd3;
  localparam logic [OP_W-1:0] OP_PSTATE = 3'd4;
  localparam logic [OP_W-1:0] OP_WRREG  = 3'd5;

  localparam int REG_VMAX  = 'h30;
  localparam int REG_FDIV  = 'h31;
  localparam int REG_SDIV  = 'h32;

  typedef enum logic [1:0] {
    RSP_NONE = 2'b00,
    RSP_ACK  = 2'b01,
    RSP_NSUP = 2'b10,
    RSP_BADA = 2'b11
  } rsp_e;

  typedef enum logic [1:0] {
    RM_FAST  = 2'd0,
    RM_SLOW  = 2'd1,
    RM_DECAY = 2'd2
  } ramp_mode_e;

endpackage

// File: rtl/vidr_cmd_dec.sv
module vidr_cmd_dec
  import vidr_pkg::*;
#(
  parameter int NUM_RAILS = 3,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter logic [2:0] PS_MASK = 3'b011
) (
  input  logic                 cmd_valid_i,
  input  logic [OP_W-1:0]      cmd_op_i,
  input  logic [ADDR_W-1:0]    cmd_addr_i,
  input  logic [DATA_W-1:0]    cmd_data_i,
  input  logic [DATA_W-1:0]    vmax_i,
  output rsp_e                 rsp_o,
  output logic [NUM_RAILS-1:0] rail_hit_o,
  output logic                 ld_ramp_o,
  output ramp_mode_e           ramp_mode_o,
  output logic                 ld_pst_o,
  output logic [1:0]           pst_val_o,
  output logic                 wr_vmax_o,
  output logic                 wr_fdiv_o,
  output logic                 wr_sdiv_o
);

  // Deepest supported state whose code does not exceed the request.
  function automatic logic [1:0] pick_state(input logic [DATA_W-1:0] req,
                                            input logic [2:0] mask);
    logic [1:0] lim;
    logic [1:0] best;
    lim  = (req > DATA_W'(2)) ? 2'd2 : req[1:0];
    best = 2'd0;
    for (int s = 0; s < 3; s++) begin
      if (mask[s] && (2'(s) <= lim)) best = 2'(s);
    end
    return best;
  endfunction

  logic any_hit;

  always_comb begin
    for (int r = 0; r < NUM_RAILS; r++) begin
      rail_hit_o[r] = (cmd_addr_i == ADDR_W'(2 * r));
    end
    any_hit = |rail_hit_o;
  end

  always_comb begin
    rsp_o       = RSP_NONE;
    ld_ramp_o   = 1'b0;
    ld_pst_o    = 1'b0;
    wr_vmax_o   = 1'b0;
    wr_fdiv_o   = 1'b0;
    wr_sdiv_o   = 1'b0;
    pst_val_o   = pick_state(cmd_data_i, PS_MASK);
    ramp_mode_o = (cmd_op_i == OP_SLOW)  ? RM_SLOW :
                  (cmd_op_i == OP_DECAY) ? RM_DECAY : RM_FAST;
    if (cmd_valid_i) begin
      rsp_o = RSP_ACK;
      case (cmd_op_i)
        OP_FAST, OP_SLOW, OP_DECAY: begin
          if (!any_hit)                 rsp_o = RSP_BADA;
          else if (cmd_data_i > vmax_i) rsp_o = RSP_NSUP;
          else                          ld_ramp_o = 1'b1;
        end
        OP_PSTATE: begin
          if (!any_hit) rsp_o = RSP_BADA;
          else          ld_pst_o = 1'b1;
        end
        OP_WRREG: begin
          if (cmd_addr_i == ADDR_W'(REG_VMAX))      wr_vmax_o = 1'b1;
          else if (cmd_addr_i == ADDR_W'(REG_FDIV)) wr_fdiv_o = 1'b1;
          else if (cmd_addr_i == ADDR_W'(REG_SDIV)) wr_sdiv_o = 1'b1;
          else                                      rsp_o = RSP_BADA;
        end
        default: rsp_o = RSP_NSUP;
      endcase
    end
  end

endmodule

// File: rtl/vidr_rail.sv
module vidr_rail
  import vidr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] RESET_VID = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sock_i,
  input  logic              decay_step_i,
  input  logic              load_i,
  input  ramp_mode_e        mode_i,
  input  logic [DATA_W-1:0] tgt_i,
  input  logic              pst_load_i,
  input  logic [1:0]        pst_i,
  input  logic [DATA_W-1:0] fdiv_i,
  input  logic [DATA_W-1:0] sdiv_i,
  output logic [DATA_W-1:0] vid_o,
  output logic              settled_o,
  output logic [1:0]        pst_o
);

  function automatic logic [DATA_W-1:0] eff_div(input logic [DATA_W-1:0] d);
    return (d == '0) ? DATA_W'(1) : d;
  endfunction

  function automatic logic [DATA_W-1:0] toward(input logic [DATA_W-1:0] cur,
                                               input logic [DATA_W-1:0] tgt);
    if (tgt > cur) return cur + DATA_W'(1);
    if (tgt < cur) return cur - DATA_W'(1);
    return cur;
  endfunction

  ramp_mode_e        mode_q;
  logic [DATA_W-1:0] vid_q, tgt_q, cnt_q, div_sel;
  logic [1:0]        pst_q;
  logic              paced, pace_tick, decay_tick, up_evt;

  assign up_evt     = load_i && (mode_i != RM_DECAY) && (tgt_i > vid_q);
  assign div_sel    = eff_div((mode_q == RM_SLOW) ? sdiv_i : fdiv_i);
  assign paced      = sock_i && (mode_q != RM_DECAY) && (vid_q != tgt_q);
  assign pace_tick  = paced && (cnt_q == div_sel - DATA_W'(1));
  assign decay_tick = sock_i && (mode_q == RM_DECAY) && decay_step_i && (vid_q > tgt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vid_q  <= RESET_VID;
      tgt_q  <= RESET_VID;
      cnt_q  <= '0;
      mode_q <= RM_FAST;
    end else if (load_i) begin
      tgt_q  <= tgt_i;
      mode_q <= mode_i;
      cnt_q  <= '0;
    end else if (pace_tick) begin
      vid_q <= toward(vid_q, tgt_q);
      cnt_q <= '0;
    end else if (paced) begin
      cnt_q <= cnt_q + DATA_W'(1);
    end else if (decay_tick) begin
      vid_q <= vid_q - DATA_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pst_q <= 2'd0;
    else if (up_evt)     pst_q <= 2'd0;
    else if (pst_load_i) pst_q <= pst_i;
  end

  assign vid_o     = vid_q;
  assign settled_o = (vid_q == tgt_q);
  assign pst_o     = pst_q;

  assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((vid_q == $past(vid_q)) || (vid_q == $past(vid_q) + DATA_W'(1)) ||
              (vid_q == $past(vid_q) - DATA_W'(1))));

  assert_decay_no_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == RM_DECAY && !load_i) |=> (vid_q <= $past(vid_q)));

  assert_decay_needs_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == RM_DECAY && !load_i && !decay_step_i) |=> $stable(vid_q));

  assert_up_forces_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    up_evt |=> (pst_q == 2'd0));

  assert_hold_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !sock_i |=> $stable(vid_q));

  assert_load_no_jump_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> $stable(vid_q));

endmodule

// File: rtl/vid_ramp_ctrl.sv
module vid_ramp_ctrl
  import vidr_pkg::*;
#(
  parameter int NUM_RAILS = 3,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter logic [DATA_W-1:0] RESET_VID    = '0,
  parameter logic [DATA_W-1:0] FAST_DIV_RST = 8'd2,
  parameter logic [DATA_W-1:0] SLOW_DIV_RST = 8'd8,
  parameter logic [2:0]        PS_MASK      = 3'b011
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          socket_present,
  input  logic                          decay_step,
  input  logic                          cmd_valid,
  input  logic [2:0]                    cmd_op,
  input  logic [ADDR_W-1:0]             cmd_addr,
  input  logic [DATA_W-1:0]             cmd_data,
  output logic                          rsp_valid,
  output logic [1:0]                    rsp_code,
  output logic [NUM_RAILS*DATA_W-1:0]   vid_now,
  output logic [NUM_RAILS-1:0]          vid_settled,
  output logic [NUM_RAILS*2-1:0]        pwr_state
);

  rsp_e                 dec_rsp;
  logic [NUM_RAILS-1:0] dec_hit;
  logic                 dec_ld_ramp, dec_ld_pst;
  ramp_mode_e           dec_mode;
  logic [1:0]           dec_pst;
  logic                 dec_wr_vmax, dec_wr_fdiv, dec_wr_sdiv;

  logic [DATA_W-1:0]    vmax_q, fdiv_q, sdiv_q;
  logic                 rsp_valid_q;
  rsp_e                 rsp_code_q;

  vidr_cmd_dec #(
    .NUM_RAILS (NUM_RAILS),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .PS_MASK   (PS_MASK)
  ) i_dec (
    .cmd_valid_i (cmd_valid),
    .cmd_op_i    (cmd_op),
    .cmd_addr_i  (cmd_addr),
    .cmd_data_i  (cmd_data),
    .vmax_i      (vmax_q),
    .rsp_o       (dec_rsp),
    .rail_hit_o  (dec_hit),
    .ld_ramp_o   (dec_ld_ramp),
    .ramp_mode_o (dec_mode),
    .ld_pst_o    (dec_ld_pst),
    .pst_val_o   (dec_pst),
    .wr_vmax_o   (dec_wr_vmax),
    .wr_fdiv_o   (dec_wr_fdiv),
    .wr_sdiv_o   (dec_wr_sdiv)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vmax_q      <= '1;
      fdiv_q      <= FAST_DIV_RST;
      sdiv_q      <= SLOW_DIV_RST;
      rsp_valid_q <= 1'b0;
      rsp_code_q  <= RSP_NONE;
    end else begin
      if (dec_wr_vmax) vmax_q <= cmd_data;
      if (dec_wr_fdiv) fdiv_q <= cmd_data;
      if (dec_wr_sdiv) sdiv_q <= cmd_data;
      rsp_valid_q <= cmd_valid;
      rsp_code_q  <= dec_rsp;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_code  = rsp_code_q;

  for (genvar r = 0; r < NUM_RAILS; r++) begin : g_rail
    vidr_rail #(
      .DATA_W    (DATA_W),
      .RESET_VID (RESET_VID)
    ) i_rail (
      .clk          (clk),
      .rst_n        (rst_n),
      .sock_i       (socket_present),
      .decay_step_i (decay_step),
      .load_i       (dec_ld_ramp && dec_hit[r]),
      .mode_i       (dec_mode),
      .tgt_i        (cmd_data),
      .pst_load_i   (dec_ld_pst && dec_hit[r]),
      .pst_i        (dec_pst),
      .fdiv_i       (fdiv_q),
      .sdiv_i       (sdiv_q),
      .vid_o        (vid_now[r*DATA_W +: DATA_W]),
      .settled_o    (vid_settled[r]),
      .pst_o        (pwr_state[r*2 +: 2])
    );
  end

  assert_rsp_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> (rsp_valid && rsp_code != 2'b00));

  assert_rsp_lone_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> !rsp_valid);

  assert_no_load_over_max_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dec_ld_ramp |-> (cmd_data <= vmax_q));

  assert_one_rail_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_ld_ramp || dec_ld_pst) |-> $onehot(dec_hit));

endmodule

// File: tb/test_vid_ramp_ctrl.sv
module test_vid_ramp_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        socket_present = 1'b1;
  logic        decay_step = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = '0;
  logic [7:0]  cmd_addr = '0;
  logic [7:0]  cmd_data = '0;
  logic        rsp_valid;
  logic [1:0]  rsp_code;
  logic [23:0] vid_now;
  logic [2:0]  vid_settled;
  logic [5:0]  pwr_state;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [1:0] exp_code_q[$];
  string      exp_req_q[$];

  localparam logic [1:0] ACK = 2'b01, NSUP = 2'b10, BADA = 2'b11;

  always #10 clk = ~clk;

  vid_ramp_ctrl i_vid_ramp_ctrl (
    .clk(clk), .rst_n(rst_n), .socket_present(socket_present),
    .decay_step(decay_step), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .rsp_valid(rsp_valid),
    .rsp_code(rsp_code), .vid_now(vid_now), .vid_settled(vid_settled),
    .pwr_state(pwr_state)
  );

  function automatic logic [7:0] vid_of(input int r);
    return vid_now[r*8 +: 8];
  endfunction

  function automatic logic [1:0] pst_of(input int r);
    return pwr_state[r*2 +: 2];
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Scoreboard monitor: every response is popped against the driver's queue.
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_code_q.size() == 0) begin
        check(1'b0, "R1", "unexpected response", rsp_code, 0);
      end else begin
        automatic logic [1:0] e = exp_code_q.pop_front();
        automatic string rq = exp_req_q.pop_front();
        check(rsp_code == e, rq, "response code", rsp_code, e);
      end
    end
  end

  task automatic send(input logic [2:0] op, input logic [7:0] addr,
                      input logic [7:0] data, input logic [1:0] exp,
                      input string req);
    exp_code_q.push_back(exp);
    exp_req_q.push_back(req);
    cmd_op = op; cmd_addr = addr; cmd_data = data; cmd_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Counts cycles from the accepting edge until the rail reports settled.
  task automatic settle(input int r, input int exp_n, input logic [7:0] exp_vid,
                        input string req);
    int n = 0;
    while (!vid_settled[r] && n < 2000) begin
      @(negedge clk);
      n++;
    end
    check(n == exp_n, req, "ramp cycles", n, exp_n);
    check(vid_of(r) == exp_vid, req, "final code", vid_of(r), exp_vid);
  endtask

  task automatic strobe(input int n);
    for (int i = 0; i < n; i++) begin
      decay_step = 1'b1;
      @(negedge clk);
      decay_step = 1'b0;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R13: reset state
    check(vid_now == 24'h0, "R13", "reset codes", vid_now, 0);
    check(vid_settled == 3'b111, "R13", "reset settled", vid_settled, 7);
    check(pwr_state == 6'h0 && !rsp_valid, "R13", "reset state/rsp", pwr_state, 0);

    // R2, R12: fast and slow pacing at reset dividers
    send(3'd1, 8'h00, 8'h05, ACK, "R2");
    check(!vid_settled[0], "R12", "not settled while ramping", vid_settled[0], 0);
    settle(0, 10, 8'h05, "R2");
    send(3'd2, 8'h02, 8'h03, ACK, "R2");
    settle(1, 24, 8'h03, "R2");

    // R3: fast divider rewritten
    send(3'd5, 8'h31, 8'h03, ACK, "R3");
    send(3'd1, 8'h04, 8'h04, ACK, "R3");
    settle(2, 12, 8'h04, "R3");

    // R5: bad addresses
    send(3'd1, 8'h01, 8'h09, BADA, "R5");
    send(3'd1, 8'h06, 8'h09, BADA, "R5");
    send(3'd5, 8'h33, 8'h09, BADA, "R5");
    send(3'd4, 8'h03, 8'h01, BADA, "R5");
    idle(10);
    check(vid_of(0) == 8'h05 && vid_of(1) == 8'h03 && vid_of(2) == 8'h04,
          "R5", "codes after bad address", vid_now, 24'h040305);
    check(pwr_state == 6'h0, "R5", "state after bad address", pwr_state, 0);

    // R11: unknown opcodes
    send(3'd7, 8'h00, 8'h10, NSUP, "R11");
    send(3'd0, 8'h00, 8'h10, NSUP, "R11");
    idle(10);
    check(vid_of(0) == 8'h05 && vid_settled[0], "R11", "rail0 untouched", vid_of(0), 5);

    // R9: maximum code
    send(3'd5, 8'h30, 8'h20, ACK, "R9");
    send(3'd1, 8'h00, 8'h21, NSUP, "R9");
    idle(10);
    check(vid_of(0) == 8'h05 && vid_settled[0], "R9", "refused target", vid_of(0), 5);
    send(3'd1, 8'h00, 8'h20, ACK, "R9");
    settle(0, 81, 8'h20, "R9");

    // R4: preemption mid-ramp in the other direction
    send(3'd2, 8'h02, 8'h1F, ACK, "R4");
    idle(40);
    check(vid_of(1) == 8'h08, "R4", "slow ramp progress", vid_of(1), 8);
    send(3'd1, 8'h02, 8'h02, ACK, "R4");
    check(vid_of(1) == 8'h08, "R4", "no jump on preempt", vid_of(1), 8);
    settle(1, 18, 8'h02, "R4");

    // R6: decay
    send(3'd3, 8'h00, 8'h1C, ACK, "R6");
    idle(20);
    check(vid_of(0) == 8'h20, "R6", "no strobe no move", vid_of(0), 8'h20);
    strobe(3);
    check(vid_of(0) == 8'h1D, "R6", "three strobes", vid_of(0), 8'h1D);
    strobe(4);
    check(vid_of(0) == 8'h1C && vid_settled[0], "R6", "stops at target", vid_of(0), 8'h1C);
    send(3'd3, 8'h02, 8'h10, ACK, "R6");
    strobe(4);
    idle(20);
    check(vid_of(1) == 8'h02 && !vid_settled[1], "R6", "never rises", vid_of(1), 2);

    // R7, R8: power states
    send(3'd4, 8'h04, 8'h01, ACK, "R7");
    check(pst_of(2) == 2'd1, "R7", "light state", pst_of(2), 1);
    send(3'd4, 8'h04, 8'h02, ACK, "R7");
    check(pst_of(2) == 2'd1, "R7", "unsupported picks light", pst_of(2), 1);
    send(3'd4, 8'h04, 8'h00, ACK, "R7");
    check(pst_of(2) == 2'd0, "R7", "full state", pst_of(2), 0);
    send(3'd4, 8'h04, 8'h01, ACK, "R8");
    send(3'd1, 8'h04, 8'h02, ACK, "R8");
    settle(2, 6, 8'h02, "R8");
    check(pst_of(2) == 2'd1, "R8", "down keeps state", pst_of(2), 1);
    send(3'd1, 8'h04, 8'h06, ACK, "R8");
    check(pst_of(2) == 2'd0, "R8", "up forces full", pst_of(2), 0);
    settle(2, 12, 8'h06, "R8");

    // R10: empty socket freezes rails
    socket_present = 1'b0;
    send(3'd1, 8'h00, 8'h1E, ACK, "R10");
    idle(20);
    check(vid_of(0) == 8'h1C, "R10", "frozen when empty", vid_of(0), 8'h1C);
    socket_present = 1'b1;
    settle(0, 6, 8'h1E, "R10");

    // R3: divider value zero acts as one (rail1 sits at 02h)
    send(3'd5, 8'h32, 8'h00, ACK, "R3");
    send(3'd2, 8'h02, 8'h04, ACK, "R3");
    settle(1, 2, 8'h04, "R3");

    idle(3);
    check(exp_code_q.size() == 0, "R1", "responses outstanding", exp_code_q.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule